// File: doc/BRIEF.md
# Soft-Sample Block Loader for an Iterative Decoder

This block sits at the entry of an iterative soft-input decoder. A start pulse opens a block. On that edge the loader latches a 4-bit block-size code and a 4-bit iteration count. From then on it takes one packed soft-value word on each accepted clock until it holds the block length plus six tail words.

Each word is split into two writes. The systematic field goes to a systematic store and the four parity fields go to a parity store. Both writes use the same running index as their address, and the write-enable and write-data outputs are combinational from the accepted input. Certain parity fields carry no information during the two tail phases; the loader writes those fields as zero, which is a neutral soft value.

The latched block size and iteration count are held on outputs for a downstream scheduler. A one-cycle strobe tells that scheduler the input is complete.

Top module: `tdec_in_loader`

## Requirements
- R1: A start is accepted on a rising edge where `start`, `nd` and `ce` are high, `ready_first` is high, the size code is valid and `iter_in` is nonzero. That same edge writes the first word at address 0 in both stores, and `ready_first` is low from the next cycle.
- R2: A start with size code 13, 14 or 15, or with `iter_in` equal to 0, writes nothing and leaves `ready_first` high.
- R3: The size codes 0 to 12 select the block sizes 122, 250, 506, 762, 1018, 1530, 2042, 3066, 4090, 5114, 6138, 8186 and 12282. After an accepted start, `cfg_bsize` shows the selected size and `cfg_iter` shows the latched count.
- R4: A block accepts exactly block_size+6 words, one on each clock with `nd` and `ce` both high. A clock with `nd` low or `ce` low writes nothing. Once the last word has been taken, `nd` causes no write.
- R5: Word number k of a block (counting from 0) is written with `sys_addr` = `par_addr` = k. The range of k is 0 to block_size+5, and `sys_we` equals `par_we`.
- R6: `ready_data` is high while idle and while loading. In the cycle after the last word, `ready_data` and `ready_first` are low and `load_done` is high. In the cycle after that, `ready_first` is high again and `load_done` is low.
- R7: The input word holds five fields of FIELD_W bits, with field c at bits [c*FIELD_W +: FIELD_W]. Field 0 is systematic, fields 1 and 2 are the first encoder's parity, and fields 3 and 4 are the second encoder's parity. For words block_size to block_size+2, fields 3 and 4 are written to the parity store as zero.
- R8: For words block_size+3 to block_size+5, fields 1 and 2 are written to the parity store as zero. Field 0 is still written unchanged to the systematic store, where it holds the second encoder's tail value.
- R9: For words 0 to block_size-1, `sys_wdata` is field 0 and `par_wdata` is fields 1 to 4 in the same order, all unchanged.
- R10: `sclr` returns the block to the idle state (`ready_first` high) only on an edge where `ce` is high. `arst` does so immediately, without waiting for a clock edge.
- R11: Changes on `iter_in` or `bsel_in` after the start edge do not affect `cfg_iter`, `cfg_bsize` or the block length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| arst | input | 1 | Asynchronous clear, active high |
| sclr | input | 1 | Synchronous clear, qualified by ce |
| ce | input | 1 | Clock enable; low holds all state |
| start | input | 1 | Starts a block; qualified by nd and ce |
| nd | input | 1 | New input word present on din |
| iter_in | input | 4 | Iteration count, sampled at start |
| bsel_in | input | 4 | Block-size code, sampled at start |
| din | input | 5*FIELD_W | Packed soft word, five fields |
| ready_first | output | 1 | A new block may be started |
| ready_data | output | 1 | Input words may be presented |
| sys_we | output | 1 | Systematic store write enable |
| sys_addr | output | ADDR_W | Systematic store write address |
| sys_wdata | output | FIELD_W | Systematic store write data |
| par_we | output | 1 | Parity store write enable |
| par_addr | output | ADDR_W | Parity store write address |
| par_wdata | output | 4*FIELD_W | Parity store write data, fields 1 to 4 |
| cfg_iter | output | 4 | Latched iteration count |
| cfg_bsize | output | ADDR_W | Latched block size in words, tail excluded |
| load_done | output | 1 | One-cycle strobe after the last word |

## Verification
The hardest points to reach are the two boundaries between phases: the change from data to first tail phase at word block_size, and the change from first to second tail phase three words later. The masking changes at exactly those indices, and a miscount there would not show up anywhere else. The bench drives complete blocks word by word and works out each word's phase from its own index count. It mixes in clocks with `nd` low and clocks with `ce` low so that stalls land before those boundaries. It also loads one block of the largest size, so that the address counter reaches its top value.

// File: rtl/tdec_in_pkg.sv
package tdec_in_pkg;
   localparam int NUM_FIELDS = 5;
   localparam int NUM_PAR    = 4;
   localparam int TAIL_LEN   = 6;
   localparam int TAIL_HALF  = 3;

   typedef enum logic [1:0] {LD_IDLE, LD_FILL, LD_DONE} ld_state_t;
   typedef enum logic [1:0] {PH_DATA, PH_TAIL1, PH_TAIL2} ld_phase_t;
endpackage

// File: rtl/tdec_bsize_lut.sv
module tdec_bsize_lut #(
   parameter int SIZE_W = 14
) (
   input  logic [3:0]        code,
   output logic [SIZE_W-1:0] size,
   output logic              valid
);
   if (SIZE_W < 14) begin : g_bad_width
      $error("tdec_bsize_lut: SIZE_W must hold 12287");
   end

   always_comb begin
      valid = 1'b1;
      case (code)
         4'd0:    size = SIZE_W'(122);
         4'd1:    size = SIZE_W'(250);
         4'd2:    size = SIZE_W'(506);
         4'd3:    size = SIZE_W'(762);
         4'd4:    size = SIZE_W'(1018);
         4'd5:    size = SIZE_W'(1530);
         4'd6:    size = SIZE_W'(2042);
         4'd7:    size = SIZE_W'(3066);
         4'd8:    size = SIZE_W'(4090);
         4'd9:    size = SIZE_W'(5114);
         4'd10:   size = SIZE_W'(6138);
         4'd11:   size = SIZE_W'(8186);
         4'd12:   size = SIZE_W'(12282);
         default: begin
            size  = '0;
            valid = 1'b0;
         end
      endcase
   end
endmodule

// File: rtl/tdec_load_ctrl.sv
module tdec_load_ctrl
   import tdec_in_pkg::*;
#(
   parameter int ADDR_W = 14
) (
   input  logic              clk,
   input  logic              arst,
   input  logic              sclr,
   input  logic              ce,
   input  logic              start,
   input  logic              nd,
   input  logic [3:0]        iter_in,
   input  logic [ADDR_W-1:0] size_in,
   input  logic              size_ok,
   output logic              ready_first,
   output logic              ready_data,
   output logic              accept,
   output logic [ADDR_W-1:0] idx,
   output ld_phase_t         phase,
   output logic [3:0]        cfg_iter,
   output logic [ADDR_W-1:0] cfg_bsize,
   output logic              load_done
);
   ld_state_t         state;
   logic [ADDR_W-1:0] cnt;
   logic [ADDR_W-1:0] last_idx;
   logic [ADDR_W-1:0] tail2_idx;
   logic              start_ok;

   assign last_idx  = cfg_bsize + ADDR_W'(TAIL_LEN - 1);
   assign tail2_idx = cfg_bsize + ADDR_W'(TAIL_HALF);
   assign start_ok  = (state == LD_IDLE) && start && nd && size_ok && (iter_in != 4'd0);
   assign accept    = ce && (start_ok || ((state == LD_FILL) && nd));
   assign idx       = (state == LD_FILL) ? cnt : '0;

   always_comb begin
      if (state != LD_FILL || idx < cfg_bsize) phase = PH_DATA;
      else if (idx < tail2_idx)                phase = PH_TAIL1;
      else                                     phase = PH_TAIL2;
   end

   assign ready_first = (state == LD_IDLE);
   assign ready_data  = (state != LD_DONE);
   assign load_done   = (state == LD_DONE);

   always_ff @(posedge clk or posedge arst) begin
      if (arst) begin
         state     <= LD_IDLE;
         cnt       <= '0;
         cfg_iter  <= '0;
         cfg_bsize <= '0;
      end else if (ce) begin
         if (sclr) begin
            state <= LD_IDLE;
            cnt   <= '0;
         end else begin
            case (state)
               LD_IDLE: if (start_ok) begin
                  state     <= LD_FILL;
                  cnt       <= ADDR_W'(1);
                  cfg_iter  <= iter_in;
                  cfg_bsize <= size_in;
               end
               LD_FILL: if (nd) begin
                  if (cnt == last_idx) begin
                     state <= LD_DONE;
                     cnt   <= '0;
                  end else begin
                     cnt <= cnt + ADDR_W'(1);
                  end
               end
               default: state <= LD_IDLE;
            endcase
         end
      end
   end

   assert_fill_bound_R4: assert property (@(posedge clk) disable iff (arst)
      (state == LD_FILL) |-> (cnt <= last_idx));
   assert_ce_hold_R4: assert property (@(posedge clk) disable iff (arst)
      !ce |=> ($stable(cnt) && $stable(state)));
   assert_rffd_drop_R1: assert property (@(posedge clk) disable iff (arst)
      (accept && state == LD_IDLE && !sclr) |=> !ready_first);
   assert_done_pulse_R6: assert property (@(posedge clk) disable iff (arst)
      (state == LD_DONE && ce) |=> (state == LD_IDLE));
   assert_cfg_hold_R11: assert property (@(posedge clk) disable iff (arst)
      (state == LD_FILL) |=> ($stable(cfg_iter) && $stable(cfg_bsize)));
endmodule

// File: rtl/tdec_field_mask.sv
module tdec_field_mask
   import tdec_in_pkg::*;
#(
   parameter int FIELD_W = 5
) (
   input  logic [NUM_FIELDS*FIELD_W-1:0] din,
   input  ld_phase_t                     phase,
   output logic [FIELD_W-1:0]            sys_out,
   output logic [NUM_PAR*FIELD_W-1:0]    par_out
);
   assign sys_out = din[FIELD_W-1:0];

   for (genvar i = 0; i < NUM_PAR; i++) begin : g_par
      logic keep;
      if (i < NUM_PAR / 2) begin : g_enc1
         assign keep = (phase != PH_TAIL2);
      end else begin : g_enc2
         assign keep = (phase != PH_TAIL1);
      end
      assign par_out[i*FIELD_W +: FIELD_W] = keep ? din[(i+1)*FIELD_W +: FIELD_W] : '0;
   end
endmodule

// File: rtl/tdec_in_loader.sv
module tdec_in_loader
   import tdec_in_pkg::*;
#(
   parameter int FIELD_W = 5,
   parameter int ADDR_W  = 14
) (
   input  logic                          clk,
   input  logic                          arst,
   input  logic                          sclr,
   input  logic                          ce,
   input  logic                          start,
   input  logic                          nd,
   input  logic [3:0]                    iter_in,
   input  logic [3:0]                    bsel_in,
   input  logic [NUM_FIELDS*FIELD_W-1:0] din,
   output logic                          ready_first,
   output logic                          ready_data,
   output logic                          sys_we,
   output logic [ADDR_W-1:0]             sys_addr,
   output logic [FIELD_W-1:0]            sys_wdata,
   output logic                          par_we,
   output logic [ADDR_W-1:0]             par_addr,
   output logic [NUM_PAR*FIELD_W-1:0]    par_wdata,
   output logic [3:0]                    cfg_iter,
   output logic [ADDR_W-1:0]             cfg_bsize,
   output logic                          load_done
);
   localparam int HALF_W = (NUM_PAR / 2) * FIELD_W;

   if (FIELD_W < 3 || FIELD_W > 9) begin : g_bad_field
      $error("tdec_in_loader: FIELD_W out of range");
   end
   if (ADDR_W < 14) begin : g_bad_addr
      $error("tdec_in_loader: ADDR_W too small for the largest block");
   end

   logic [ADDR_W-1:0] lut_size;
   logic              lut_ok;
   logic              accept;
   logic [ADDR_W-1:0] idx;
   ld_phase_t         phase;

   tdec_bsize_lut #(.SIZE_W(ADDR_W)) u_lut (
      .code (bsel_in),
      .size (lut_size),
      .valid(lut_ok)
   );

   tdec_load_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
      .clk        (clk),
      .arst       (arst),
      .sclr       (sclr),
      .ce         (ce),
      .start      (start),
      .nd         (nd),
      .iter_in    (iter_in),
      .size_in    (lut_size),
      .size_ok    (lut_ok),
      .ready_first(ready_first),
      .ready_data (ready_data),
      .accept     (accept),
      .idx        (idx),
      .phase      (phase),
      .cfg_iter   (cfg_iter),
      .cfg_bsize  (cfg_bsize),
      .load_done  (load_done)
   );

   tdec_field_mask #(.FIELD_W(FIELD_W)) u_mask (
      .din    (din),
      .phase  (phase),
      .sys_out(sys_wdata),
      .par_out(par_wdata)
   );

   assign sys_we   = accept;
   assign par_we   = accept;
   assign sys_addr = idx;
   assign par_addr = idx;

   assert_tail1_zero_R7: assert property (@(posedge clk) disable iff (arst)
      (par_we && phase == PH_TAIL1) |-> (par_wdata[NUM_PAR*FIELD_W-1:HALF_W] == '0));
   assert_tail2_zero_R8: assert property (@(posedge clk) disable iff (arst)
      (par_we && phase == PH_TAIL2) |-> (par_wdata[HALF_W-1:0] == '0));
   assert_no_write_idle_R4: assert property (@(posedge clk) disable iff (arst)
      (sys_we && !ready_first) |-> (ready_data && nd && ce));
endmodule

// File: tb/tdec_in_loader_tb.sv
module tdec_in_loader_tb;
   localparam int FW = 5;
   localparam int AW = 14;

   logic          clk = 1'b0;
   logic          arst = 1'b0, sclr = 1'b0, ce = 1'b1, start = 1'b0, nd = 1'b0;
   logic [3:0]    iter_in = '0, bsel_in = '0;
   logic [5*FW-1:0] din = '0;
   logic          ready_first, ready_data, sys_we, par_we, load_done;
   logic [AW-1:0] sys_addr, par_addr, cfg_bsize;
   logic [FW-1:0] sys_wdata;
   logic [4*FW-1:0] par_wdata;
   logic [3:0]    cfg_iter;

   int n_checks = 0;
   int n_fail   = 0;

   always #4 clk = ~clk;

   tdec_in_loader #(.FIELD_W(FW), .ADDR_W(AW)) u_dut (
      .clk(clk), .arst(arst), .sclr(sclr), .ce(ce), .start(start), .nd(nd),
      .iter_in(iter_in), .bsel_in(bsel_in), .din(din),
      .ready_first(ready_first), .ready_data(ready_data),
      .sys_we(sys_we), .sys_addr(sys_addr), .sys_wdata(sys_wdata),
      .par_we(par_we), .par_addr(par_addr), .par_wdata(par_wdata),
      .cfg_iter(cfg_iter), .cfg_bsize(cfg_bsize), .load_done(load_done)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_size(input int code);
      case (code)
         0: return 122;   1: return 250;   2: return 506;   3: return 762;
         4: return 1018;  5: return 1530;  6: return 2042;  7: return 3066;
         8: return 4090;  9: return 5114;  10: return 6138; 11: return 8186;
         default: return 12282;
      endcase
   endfunction

   function automatic logic [FW-1:0] fld(input int k, input int c);
      return FW'(((k + c * 7) % 31) + 1);
   endfunction

   function automatic logic [5*FW-1:0] word(input int k);
      logic [5*FW-1:0] w;
      for (int c = 0; c < 5; c++) w[c*FW +: FW] = fld(k, c);
      return w;
   endfunction

   function automatic logic [4*FW-1:0] exp_par(input int k, input int n);
      logic [4*FW-1:0] p;
      for (int c = 1; c < 5; c++) begin
         if (k >= n && k < n + 3 && c >= 3)   p[(c-1)*FW +: FW] = '0;
         else if (k >= n + 3 && c <= 2)       p[(c-1)*FW +: FW] = '0;
         else                                 p[(c-1)*FW +: FW] = fld(k, c);
      end
      return p;
   endfunction

   task automatic t_reset();
      @(negedge clk); #1;
      chk(ready_first == 1'b1, "R6 reset ready_first", ready_first, 1);
      chk(ready_data == 1'b1 && load_done == 1'b0, "R6 reset ready_data/load_done",
          {ready_data, load_done}, 2);
      chk(sys_we == 1'b0 && par_we == 1'b0, "R4 reset no write", sys_we, 0);
   endtask

   // gap: 0 none, 1 nd-low stalls, 2 ce-low stalls
   task automatic t_load(input int code, input int it, input int gap);
      int n = exp_size(code);
      int e_data = 0, e_t1 = 0, e_t2 = 0, e_addr = 0, e_gap = 0, e_rdy = 0;
      @(negedge clk);
      start = 1; nd = 1; iter_in = 4'(it); bsel_in = 4'(code); din = word(0); #1;
      chk(sys_we && par_we && sys_addr == 0 && par_addr == 0, "R1 first word at address 0",
          sys_addr, 0);
      chk(sys_wdata == fld(0, 0) && par_wdata == exp_par(0, n), "R1 first word data",
          sys_wdata, fld(0, 0));
      for (int k = 1; k < n + 6; k++) begin
         if (gap != 0 && (k % 17) == 0) begin
            @(negedge clk);
            start = 0;
            if (gap == 1) nd = 0; else ce = 0;
            #1;
            if (sys_we || par_we) e_gap++;
         end
         @(negedge clk);
         start = 0; nd = 1; ce = 1; din = word(k);
         if (k == 1) begin iter_in = 4'(~it); bsel_in = 4'hF; end
         if (k == 2) bsel_in = 4'd0;
         #1;
         if (ready_first || !ready_data) e_rdy++;
         if (!sys_we || !par_we || sys_addr != AW'(k) || par_addr != AW'(k)) e_addr++;
         if (sys_wdata != fld(k, 0) || par_wdata != exp_par(k, n)) begin
            if (k < n) e_data++;
            else if (k < n + 3) e_t1++;
            else e_t2++;
         end
      end
      chk(e_addr == 0, "R5 address count 0..N+5", e_addr, 0);
      chk(e_data == 0, "R9 data phase fields unchanged", e_data, 0);
      chk(e_t1 == 0, "R7 first tail phase masking", e_t1, 0);
      chk(e_t2 == 0, "R8 second tail phase masking", e_t2, 0);
      chk(e_rdy == 0, "R6 ready flags while loading", e_rdy, 0);
      if (gap != 0) chk(e_gap == 0, "R4 stalled clock writes nothing", e_gap, 0);
      @(negedge clk);
      nd = 1; din = word(999); #1;
      chk(!ready_data && !ready_first && load_done, "R6 done cycle flags",
          {ready_data, ready_first, load_done}, 1);
      chk(!sys_we && !par_we, "R4 nd ignored after full count", sys_we, 0);
      chk(cfg_iter == 4'(it) && cfg_bsize == AW'(n), "R11 R3 latched config held",
          cfg_bsize, n);
      @(negedge clk);
      nd = 0; #1;
      chk(ready_first && ready_data && !load_done, "R6 back to idle",
          {ready_first, ready_data, load_done}, 6);
   endtask

   task automatic t_reject(input int code, input int it);
      @(negedge clk);
      start = 1; nd = 1; ce = 1; iter_in = 4'(it); bsel_in = 4'(code); din = word(3); #1;
      chk(!sys_we && !par_we, "R2 rejected start writes nothing", sys_we, 0);
      @(negedge clk);
      start = 0; nd = 0; #1;
      chk(ready_first == 1'b1, "R2 rejected start keeps ready_first", ready_first, 1);
   endtask

   task automatic t_start_gated();
      @(negedge clk);
      start = 1; nd = 1; ce = 0; iter_in = 4'd2; bsel_in = 4'd0; #1;
      chk(!sys_we, "R4 ce low start writes nothing", sys_we, 0);
      @(negedge clk);
      ce = 1; nd = 0; #1;
      chk(!sys_we, "R1 start without nd writes nothing", sys_we, 0);
      @(negedge clk);
      start = 0; #1;
      chk(ready_first == 1'b1, "R1 gated start stays idle", ready_first, 1);
   endtask

   task automatic t_codes();
      for (int c = 0; c < 13; c++) begin
         @(negedge clk);
         start = 1; nd = 1; ce = 1; iter_in = 4'(c + 1); bsel_in = 4'(c); din = word(c);
         @(negedge clk);
         start = 0; nd = 0; #1;
         chk(cfg_bsize == AW'(exp_size(c)) && cfg_iter == 4'(c + 1), "R3 size code map",
             cfg_bsize, exp_size(c));
         sclr = 1; ce = 0;
         @(negedge clk);
         sclr = 0; ce = 1; #1;
         chk(ready_first == 1'b0, "R10 sclr ignored with ce low", ready_first, 0);
         sclr = 1;
         @(negedge clk);
         sclr = 0; #1;
         chk(ready_first == 1'b1, "R10 sclr with ce returns to idle", ready_first, 1);
      end
   endtask

   task automatic t_arst();
      @(negedge clk);
      start = 1; nd = 1; ce = 1; iter_in = 4'd4; bsel_in = 4'd1; din = word(0);
      for (int k = 1; k < 4; k++) begin
         @(negedge clk);
         start = 0; din = word(k);
      end
      nd = 0;
      #1;
      chk(ready_first == 1'b0, "R10 loading before arst", ready_first, 0);
      #1 arst = 1; #1;
      chk(ready_first == 1'b1, "R10 arst clears without a clock edge", ready_first, 1);
      @(negedge clk);
      @(negedge clk);
      arst = 0;
      @(negedge clk);
      start = 1; nd = 1; iter_in = 4'd1; bsel_in = 4'd0; din = word(0); #1;
      chk(sys_we && sys_addr == 0, "R10 new block after arst starts at 0", sys_addr, 0);
      @(negedge clk);
      start = 0; nd = 0;
      sclr = 1;
      @(negedge clk);
      sclr = 0;
   endtask

   initial begin
      #(200000 * 8);
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      arst = 1;
      repeat (2) @(negedge clk);
      arst = 0;
      t_reset();
      t_load(0, 3, 0);
      t_load(0, 15, 1);
      t_load(2, 7, 2);
      t_reject(13, 3);
      t_reject(15, 8);
      t_reject(0, 0);
      t_start_gated();
      t_codes();
      t_arst();
      t_load(12, 1, 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule